// File: doc/BRIEF.md
# Subtract-and-Branch Processor

This block is a minimal multicycle processor with a single instruction. Each instruction is three consecutive memory words: a source address, a destination address and a branch target. The block subtracts the source word from the destination word and stores the difference back at the destination. If that difference, read as a two's-complement number, is zero or negative, the program counter takes the target. Otherwise it moves on to the next three-word instruction. Clear, jump and add have no opcodes of their own. A program builds them from short sequences of this one instruction, working on memory operands and a scratch word that holds zero.

The processor drives one synchronous, word-addressed memory that holds both code and data. A read returns its data one cycle after the address is presented. Each instruction takes seven cycles: three operand fetches, two data reads, one write-back and one program-counter update. A `run` input lets the sequencer start a new instruction. When a taken branch points at the all-ones address, the block stops and raises `halted` until the next reset.

Top module: `subbr_cpu`

## Requirements
- R1: An instruction at program counter P takes its source address from word P, its destination address from word P+1 and its target from word P+2. Only the low ADDR_W bits of each word are used as an address.
- R2: Each instruction performs exactly one memory write. It stores Mem[dst] minus Mem[src], modulo 2^DATA_W, at the destination address.
- R3: When the stored difference, taken as signed two's complement, is zero or negative, the program counter loads the target.
- R4: When the stored difference is strictly positive, the program counter advances by three, modulo 2^ADDR_W.
- R5: While `run` is low at an instruction boundary, the block stays idle and performs no writes. An instruction already under way still completes. When `run` returns high, execution resumes at the next instruction.
- R6: After reset, `halted` is low, the program counter is 0 (so `mem_addr` is 0) and `mem_we` is low.
- R7: A taken branch whose target field is all ones raises `halted` after that instruction's write. `halted` stays high until reset, and no further writes occur whatever `run` does.
- R8: Macro sequences built from the instruction give the expected results. A self-subtract with the next address as target clears a word. A scratch self-subtract jumps. The three-step sequence through the scratch word adds one word into another and leaves the scratch word at zero.
- R9: Each instruction takes seven clock cycles. A program that executes n instructions, the last of which halts, raises `halted` 7·n clock edges after the edge that first samples `run` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Allows a new instruction to begin |
| halted | output | 1 | High once a branch to the all-ones address has been taken |
| mem_addr | output | ADDR_W | Word address to memory |
| mem_wdata | output | DATA_W | Data written at the destination address |
| mem_we | output | 1 | Write strobe, one cycle per instruction |
| mem_rdata | input | DATA_W | Read data, valid one cycle after its address |

## Verification
The bench sweeps operand pairs whose difference sits on every edge of the sign test. These include exactly zero, plus and minus one, and subtractions that overflow past the most positive or most negative value. A design that branched only on strictly negative values, or that used an unsigned compare, would clear the wrong marker word. It also runs clear, jump and add sequences and compares the whole memory image with a model in the bench, so a swapped operand order or a wrong fall-through stride would show up as a corrupted word. Pausing `run` in the middle of an instruction, and toggling it after a halt, exposes a sequencer that drops a half-done write or writes again after stopping. Cycle counts to halt catch any extra or missing state.

// File: rtl/subbr_pkg.sv
package subbr_pkg;

   // Sequencer states, one per memory access plus idle, update and halt.
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FA,     // present PC      (source address word)
      ST_FB,     // present PC+1    (destination address word)
      ST_FT,     // present PC+2    (target word)
      ST_RA,     // present source address
      ST_RB,     // present destination address
      ST_WB,     // write difference back to destination
      ST_PC,     // program counter update
      ST_HALT
   } state_t;

   localparam int unsigned OPND_WORDS = 3;

endpackage

// File: rtl/subbr_seq.sv
module subbr_seq
   import subbr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   run,
   input  logic   halt_hit,
   output state_t state
);

   state_t state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: state_nx = run ? ST_FA : ST_IDLE;
         ST_FA:   state_nx = ST_FB;
         ST_FB:   state_nx = ST_FT;
         ST_FT:   state_nx = ST_RA;
         ST_RA:   state_nx = ST_RB;
         ST_RB:   state_nx = ST_WB;
         ST_WB:   state_nx = ST_PC;
         ST_PC: begin
            if (halt_hit)  state_nx = ST_HALT;
            else if (run)  state_nx = ST_FA;
            else           state_nx = ST_IDLE;
         end
         ST_HALT: state_nx = ST_HALT;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT) |=> (state == ST_HALT));                        // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !run) |=> (state == ST_IDLE));                // R5

endmodule

// File: rtl/subbr_opnd.sv
module subbr_opnd
   import subbr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  state_t            state,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] src_adr,
   output logic [ADDR_W-1:0] dst_adr,
   output logic [ADDR_W-1:0] tgt_adr,
   output logic [DATA_W-1:0] src_val
);

   // Data presented in state S is returned during the following state,
   // so each register captures in the state after its fetch.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_adr <= '0;
         dst_adr <= '0;
         tgt_adr <= '0;
         src_val <= '0;
      end else begin
         unique case (state)
            ST_FB:   src_adr <= rdata[ADDR_W-1:0];
            ST_FT:   dst_adr <= rdata[ADDR_W-1:0];
            ST_RA:   tgt_adr <= rdata[ADDR_W-1:0];
            ST_RB:   src_val <= rdata;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/subbr_alu.sv
module subbr_alu #(
   parameter int DATA_W    = 32,
   parameter bit LE_BY_MSB = 1'b1
)(
   input  logic [DATA_W-1:0] minuend,
   input  logic [DATA_W-1:0] subtrahend,
   output logic [DATA_W-1:0] diff,
   output logic              le_zero
);

   assign diff = minuend - subtrahend;

   generate
      if (LE_BY_MSB) begin : g_msb
         // sign bit or all-zero detect: shallow logic
         assign le_zero = diff[DATA_W-1] | ~(|diff);
      end else begin : g_cmp
         assign le_zero = ($signed(diff) <= $signed({DATA_W{1'b0}}));
      end
   endgenerate

endmodule

// File: rtl/subbr_pc.sv
module subbr_pc #(
   parameter int ADDR_W   = 8,
   parameter int RESET_PC = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic              take,
   input  logic [ADDR_W-1:0] tgt,
   output logic [ADDR_W-1:0] pc
);

   localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(subbr_pkg::OPND_WORDS);
   localparam logic [ADDR_W-1:0] PC0    = ADDR_W'(RESET_PC);

   always_ff @(posedge clk) begin
      if (!rst_n)   pc <= PC0;
      else if (upd) pc <= take ? tgt : pc + STRIDE;
   end

   AST_PC_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !take) |=> (pc == ADDR_W'($past(pc) + STRIDE)));           // R4
   AST_PC_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && take) |=> (pc == $past(tgt)));                             // R3

endmodule

// File: rtl/subbr_cpu.sv
module subbr_cpu
   import subbr_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int RESET_PC  = 0,
   parameter bit HALT_EN   = 1'b1,
   parameter bit LE_BY_MSB = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   output logic              halted,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam logic [ADDR_W-1:0] HALT_ADR = {ADDR_W{1'b1}};

   generate
      if (ADDR_W < 2) begin : g_bad_aw
         $error("subbr_cpu: ADDR_W must be at least 2");
      end
      if (ADDR_W > DATA_W) begin : g_bad_dw
         $error("subbr_cpu: an address must fit in a data word");
      end
      if (RESET_PC < 0 || RESET_PC >= (1 << ADDR_W)) begin : g_bad_pc
         $error("subbr_cpu: RESET_PC outside address space");
      end
   endgenerate

   state_t            state;
   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] src_adr, dst_adr, tgt_adr;
   logic [DATA_W-1:0] src_val;
   logic [DATA_W-1:0] diff;
   logic              le_zero;
   logic              take_q;
   logic              halt_hit;
   logic              pc_upd;

   subbr_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .halt_hit (halt_hit),
      .state    (state)
   );

   subbr_opnd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_opnd (
      .clk     (clk),
      .rst_n   (rst_n),
      .state   (state),
      .rdata   (mem_rdata),
      .src_adr (src_adr),
      .dst_adr (dst_adr),
      .tgt_adr (tgt_adr),
      .src_val (src_val)
   );

   // destination value arrives on mem_rdata during the write-back state
   subbr_alu #(.DATA_W(DATA_W), .LE_BY_MSB(LE_BY_MSB)) u_alu (
      .minuend    (mem_rdata),
      .subtrahend (src_val),
      .diff       (diff),
      .le_zero    (le_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)              take_q <= 1'b0;
      else if (state == ST_WB) take_q <= le_zero;
   end

   generate
      if (HALT_EN) begin : g_halt
         assign halt_hit = take_q && (tgt_adr == HALT_ADR);
      end else begin : g_nohalt
         assign halt_hit = 1'b0;
      end
   endgenerate

   assign pc_upd = (state == ST_PC) && !halt_hit;

   subbr_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (pc_upd),
      .take  (take_q),
      .tgt   (tgt_adr),
      .pc    (pc)
   );

   always_comb begin
      unique case (state)
         ST_FB:        mem_addr = pc + ADDR_W'(1);
         ST_FT:        mem_addr = pc + ADDR_W'(2);
         ST_RA:        mem_addr = src_adr;
         ST_RB, ST_WB: mem_addr = dst_adr;
         default:      mem_addr = pc;
      endcase
   end

   assign mem_we    = (state == ST_WB);
   assign mem_wdata = diff;
   assign halted    = (state == ST_HALT);

   AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr == $past(mem_addr)));                         // R2
   AST_WR_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata == mem_rdata - $past(mem_rdata)));           // R2
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_we);                                               // R7
   AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);                                               // R2

endmodule

// File: tb/subbr_cpu_tb.sv
module subbr_cpu_tb;

   localparam int DW = 32;
   localparam int AW = 8;
   localparam int NW = 1 << AW;
   localparam logic [AW-1:0] ZR = 8'd127;   // scratch word, kept at zero

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic          halted;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we;
   logic [DW-1:0] mem_rdata;

   logic          bd_we = 1'b0;
   logic [AW-1:0] bd_addr = '0;
   logic [DW-1:0] bd_data = '0;

   logic [DW-1:0] mem  [NW];
   logic [DW-1:0] refm [NW];

   int  checks = 0;
   int  errors = 0;
   int  wr_cnt;
   bit  done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   subbr_cpu #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .halted    (halted),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (bd_we)       mem[bd_addr]  <= bd_data;
      else if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
      if (mem_we) wr_cnt <= wr_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bd(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bd_addr = a; bd_data = d; bd_we = 1'b1;
      @(negedge clk);
      bd_we = 1'b0;
      refm[a] = d;
   endtask

   task automatic ins(input logic [AW-1:0] p, input logic [AW-1:0] a,
                      input logic [AW-1:0] b, input logic [AW-1:0] t);
      bd(p, DW'(a)); bd(p + 8'd1, DW'(b)); bd(p + 8'd2, DW'(t));
   endtask

   task automatic do_reset();
      run = 1'b0; rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic clear_all();
      for (int i = 0; i < NW; i++) bd(AW'(i), '0);
   endtask

   // bench model of the instruction semantics
   task automatic ref_run(output int steps);
      logic [AW-1:0] pc, a, b, t;
      logic [DW-1:0] d;
      bit hlt;
      pc = '0; steps = 0; hlt = 1'b0;
      while (!hlt && steps < 1000) begin
         a = refm[pc][AW-1:0];
         b = refm[pc + 8'd1][AW-1:0];
         t = refm[pc + 8'd2][AW-1:0];
         d = refm[b] - refm[a];
         refm[b] = d;
         steps++;
         if ($signed(d) <= 0) begin
            if (t == 8'hFF) hlt = 1'b1;
            else            pc = t;
         end else pc = pc + 8'd3;
      end
   endtask

   task automatic run_prog(output int cyc);
      run = 1'b1;
      @(posedge clk);
      cyc = 0;
      while (!halted && cyc < 20000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
      run = 1'b0;
   endtask

   task automatic cmp_image(input string req);
      int bad = 0;
      for (int i = 0; i < NW; i++) begin
         if (mem[i] !== refm[i]) begin
            if (bad == 0)
               $display("FAIL %s memory word %0d: actual %h expected %h",
                        req, i, mem[i], refm[i]);
            bad++;
         end
      end
      checks++;
      if (bad != 0) errors++;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int steps, cyc, w0;
      logic [DW-1:0] xs [8];
      logic [DW-1:0] ys [8];

      // R6: reset state
      do_reset();
      chk(halted == 1'b0, "R6", "halted after reset", DW'(halted), 0);
      chk(mem_we == 1'b0, "R6", "write strobe after reset", DW'(mem_we), 0);
      chk(mem_addr == '0, "R6", "address after reset", DW'(mem_addr), 0);

      // R8 clear macro, R9 timing, R7 halt
      clear_all();
      bd(8'd100, 32'd1234);
      ins(8'd0, 8'd100, 8'd100, 8'd3);
      ins(8'd3, ZR, ZR, 8'hFF);
      ref_run(steps);
      run_prog(cyc);
      chk(mem[100] == '0, "R8", "clear result", mem[100], 0);
      chk(cyc == 7 * steps, "R9", "cycles to halt (clear)", DW'(cyc), DW'(7 * steps));
      chk(halted == 1'b1, "R7", "halted after clear program", DW'(halted), 1);
      cmp_image("R1");

      // R8 jump macro, R3 taken branch skips code
      do_reset();
      clear_all();
      bd(8'd101, 32'd77);
      ins(8'd0, ZR, ZR, 8'd9);
      ins(8'd3, 8'd101, 8'd101, 8'd6);
      ins(8'd6, ZR, ZR, 8'hFF);
      ins(8'd9, ZR, ZR, 8'hFF);
      ref_run(steps);
      run_prog(cyc);
      chk(mem[101] == 32'd77, "R3", "skipped word after jump", mem[101], 32'd77);
      chk(cyc == 14, "R9", "cycles to halt (jump)", DW'(cyc), 14);
      cmp_image("R8");

      // R8 add macro sweep
      xs[0] = 32'd5;        ys[0] = 32'd7;
      xs[1] = -32'sd3;      ys[1] = 32'd10;
      xs[2] = 32'd0;        ys[2] = 32'd0;
      xs[3] = 32'h7FFFFFFF; ys[3] = 32'd1;
      xs[4] = 32'hFFFFFFFF; ys[4] = 32'hFFFFFFFF;
      xs[5] = 32'd100;      ys[5] = -32'sd200;
      xs[6] = 32'h80000000; ys[6] = 32'h80000000;
      xs[7] = 32'h12345678; ys[7] = 32'h0F0F0F0F;
      for (int k = 0; k < 8; k++) begin
         do_reset();
         clear_all();
         bd(8'd102, xs[k]);
         bd(8'd103, ys[k]);
         ins(8'd0, 8'd102, ZR, 8'd3);
         ins(8'd3, ZR, 8'd103, 8'd6);
         ins(8'd6, ZR, ZR, 8'd9);
         ins(8'd9, ZR, ZR, 8'hFF);
         ref_run(steps);
         run_prog(cyc);
         chk(mem[103] == xs[k] + ys[k], "R8", "add sum", mem[103], xs[k] + ys[k]);
         chk(mem[ZR] == '0, "R8", "scratch zero after add", mem[ZR], 0);
         chk(cyc == 28, "R9", "cycles to halt (add)", DW'(cyc), 28);
      end

      // R2/R3/R4 sign edge sweep: y - x
      xs[0] = 32'd40;       ys[0] = 32'd40;         // zero -> taken
      xs[1] = 32'd40;       ys[1] = 32'd41;         // +1  -> fall through
      xs[2] = 32'd41;       ys[2] = 32'd40;         // -1  -> taken
      xs[3] = 32'd1;        ys[3] = 32'h80000000;   // wraps to max positive
      xs[4] = 32'hFFFFFFFF; ys[4] = 32'h7FFFFFFF;   // wraps to most negative
      xs[5] = 32'd0;        ys[5] = 32'h7FFFFFFF;   // max positive
      xs[6] = 32'd1;        ys[6] = 32'd0;          // all ones
      xs[7] = 32'hFFFFFFFF; ys[7] = 32'd0;          // +1 via negative source
      for (int k = 0; k < 8; k++) begin
         logic [DW-1:0] d;
         bit tk;
         d  = ys[k] - xs[k];
         tk = ($signed(d) <= 0);
         do_reset();
         clear_all();
         bd(8'd120, xs[k]);
         bd(8'd121, ys[k]);
         bd(8'd122, 32'h55);
         bd(8'd123, 32'h55);
         ins(8'd0, 8'd120, 8'd121, 8'd9);
         ins(8'd3, 8'd122, 8'd122, 8'd6);
         ins(8'd6, ZR, ZR, 8'hFF);
         ins(8'd9, 8'd123, 8'd123, 8'd12);
         ins(8'd12, ZR, ZR, 8'hFF);
         ref_run(steps);
         run_prog(cyc);
         chk(mem[121] == d, "R2", "stored difference", mem[121], d);
         if (tk) begin
            chk(mem[123] == '0 && mem[122] == 32'h55, "R3", "taken-path marker",
                mem[123], 0);
         end else begin
            chk(mem[122] == '0 && mem[123] == 32'h55, "R4", "fall-through marker",
                mem[122], 0);
         end
         cmp_image("R2");
      end

      // R5 run pause mid-instruction
      do_reset();
      clear_all();
      bd(8'd110, 32'd9);
      bd(8'd111, 32'd8);
      ins(8'd0, 8'd110, 8'd110, 8'd3);
      ins(8'd3, 8'd111, 8'd111, 8'd6);
      ins(8'd6, ZR, ZR, 8'hFF);
      ref_run(steps);
      w0 = wr_cnt;
      run = 1'b1;
      @(negedge clk);
      run = 1'b0;
      repeat (40) @(negedge clk);
      chk(wr_cnt - w0 == 1, "R5", "writes while paused", DW'(wr_cnt - w0), 1);
      chk(mem[110] == '0, "R5", "started instruction completed", mem[110], 0);
      chk(mem[111] == 32'd8, "R5", "next instruction held", mem[111], 32'd8);
      chk(halted == 1'b0, "R5", "not halted while paused", DW'(halted), 0);
      run_prog(cyc);
      chk(halted == 1'b1, "R5", "halted after resume", DW'(halted), 1);
      cmp_image("R5");

      // R7 halt is sticky and quiet
      w0 = wr_cnt;
      run = 1'b1;
      repeat (30) @(negedge clk);
      run = 1'b0;
      repeat (5) @(negedge clk);
      chk(halted == 1'b1, "R7", "halt sticky", DW'(halted), 1);
      chk(wr_cnt == w0, "R7", "writes after halt", DW'(wr_cnt - w0), 0);
      cmp_image("R7");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule